// File: doc/BRIEF.md
# Predicate Register Lookup Table

This block holds a small table that tells the instruction issue logic whether an operand register is predicated, and if so which register holds its predicate bits. Software fills the table through a one-cycle configuration write port. Each entry pairs a key with a value and two modifiers. The key is a register-file bit plus a 5-bit register number. The value is the 5-bit number of the predicate register. The modifiers are an invert flag and a zeroing flag. Several entries can be live at once, so several registers can each carry their own predicate.

On every cycle the block looks up the presented register-file bit and register number. It compares them against all valid entries in parallel. One cycle later it presents the hit flag, the predicate register number and both flags. The issue logic reads the integer register file at the returned predicate register number and feeds those contents back in the same cycle. The block then turns them, together with the vector length captured with the lookup, into a per-element enable mask and a per-element zeroing mask.

Top module: `pred_kv_table`

## Requirements
- R1: A configuration write to entry k stores the file bit, key, predicate register number, invert flag and zeroing flag, and marks the entry valid, in one cycle. A lookup presented on the next cycle sees the new contents.
- R2: A lookup presented in the same cycle as a configuration write sees the table contents from before that write.
- R3: An entry matches only if it is valid and both its file bit and its 5-bit key equal the lookup's. After reset no entry is valid, so every lookup misses.
- R4: When several entries match, the lowest-indexed one supplies the result.
- R5: The lookup result appears exactly one clock cycle after the lookup inputs are presented.
- R6: On a hit, enable bit i equals bit i of the predicate data XOR the invert flag, for every i below the captured vector length.
- R7: On a hit, zero-mask bit i is 1 exactly when enable bit i is 0 and the zeroing flag is set, for i below the vector length. The enable mask and the zero mask never share a set bit.
- R8: On a miss, the hit output is 0, the predicate register number and both flags are 0, the enable mask is all ones below the vector length, and the zero mask is all zeros.
- R9: Bits at or above the captured vector length are 0 in both masks. A vector length above the element count enables all element positions.
- R10: After reset the hit output, the predicate register number, both flags and both masks are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | $clog2(N_ENT) | Entry index to write |
| cfg_fp | input | 1 | Key file bit (1 = floating-point file) |
| cfg_key | input | 5 | Register that becomes predicated |
| cfg_preg | input | 5 | Register that holds the predicate bits |
| cfg_inv | input | 1 | Invert the predicate |
| cfg_zero | input | 1 | Zero the disabled elements |
| lk_fp | input | 1 | Lookup file bit |
| lk_reg | input | 5 | Lookup register number |
| lk_vl | input | $clog2(ELEM_MAX+1) | Vector length for this lookup |
| pred_data | input | ELEM_MAX | Contents of the predicate register named by pred_reg |
| hit | output | 1 | Registered lookup hit |
| pred_reg | output | 5 | Registered predicate register number (0 on miss) |
| pred_inv | output | 1 | Registered invert flag |
| pred_zero | output | 1 | Registered zeroing flag |
| en_mask | output | ELEM_MAX | Element enable mask |
| zero_mask | output | ELEM_MAX | Element zeroing mask |

## Verification
The bench presents a write and a lookup of the same key together. A design that forwards the new entry would report a hit a cycle early. It loads duplicate keys into entries 1 and 3. Picking the wrong entry shows up as the wrong predicate register and flags. It also presents keys that differ only in the file bit. Ignoring that bit turns a miss into a false hit. Vector lengths of 0, the full element count and values above it expose a tail mask that is off by one or does not clamp. Random runs that mix invert and zeroing settings catch masks that apply the invert twice, or zero elements that are enabled.

// File: rtl/pred_pkg.sv
// Package: shared widths and the table entry layout.
// Assumes 5-bit register numbers for both register files.
package pred_pkg;
    localparam int REG_W = 5;

    typedef struct packed {
        logic             vld;
        logic             fp;
        logic [REG_W-1:0] key;
        logic [REG_W-1:0] preg;
        logic             inv;
        logic             zero;
    } pred_ent_t;
endpackage

// File: rtl/pred_entry_store.sv
// Module: pred_entry_store
// Holds N_ENT table entries. A write replaces every field of one entry
// and sets its valid bit. Reads see register outputs, so a write becomes
// visible one cycle later.
// Assumes cfg_idx is below N_ENT when cfg_we is high.
module pred_entry_store
    import pred_pkg::*;
#(
    parameter int N_ENT = 4,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [IDX_W-1:0]       cfg_idx,
    input  logic                   cfg_fp,
    input  logic [REG_W-1:0]       cfg_key,
    input  logic [REG_W-1:0]       cfg_preg,
    input  logic                   cfg_inv,
    input  logic                   cfg_zero,
    output pred_ent_t [N_ENT-1:0]  ent_q
);

    genvar g;
    generate
        for (g = 0; g < N_ENT; g++) begin : g_ent
            // Per-entry storage: clear valid on reset, load on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ent_q[g] <= '0;
                end else if (cfg_we && (cfg_idx == IDX_W'(g))) begin
                    ent_q[g].vld  <= 1'b1;
                    ent_q[g].fp   <= cfg_fp;
                    ent_q[g].key  <= cfg_key;
                    ent_q[g].preg <= cfg_preg;
                    ent_q[g].inv  <= cfg_inv;
                    ent_q[g].zero <= cfg_zero;
                end
            end
        end
    endgenerate

    AST_WRITE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> ent_q[$past(cfg_idx)].vld); // R1
    AST_WRITE_KEEPS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (ent_q[$past(cfg_idx)].key == $past(cfg_key)) &&
                   (ent_q[$past(cfg_idx)].preg == $past(cfg_preg))); // R1

endmodule

// File: rtl/pred_match.sv
// Module: pred_match
// Compares the lookup key against every entry in parallel and selects the
// lowest-indexed match. Purely combinational.
// Assumes the entries come straight from the storage registers.
module pred_match
    import pred_pkg::*;
#(
    parameter int N_ENT = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  pred_ent_t [N_ENT-1:0]  ent,
    input  logic                   lk_fp,
    input  logic [REG_W-1:0]       lk_reg,
    output logic                   m_hit,
    output pred_ent_t              m_ent
);

    logic [N_ENT-1:0] eq;
    logic [N_ENT-1:0] grant;
    logic [N_ENT:0]   seen;

    assign seen[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < N_ENT; g++) begin : g_cmp
            // Entry compare: valid, same file, same register number.
            assign eq[g]      = ent[g].vld && (ent[g].fp == lk_fp) && (ent[g].key == lk_reg);
            // Priority chain: grant only if no lower entry matched.
            assign grant[g]   = eq[g] & ~seen[g];
            assign seen[g+1]  = seen[g] | eq[g];
        end
    endgenerate

    // Result mux: OR of the granted entry (at most one grant).
    always_comb begin
        m_ent = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (grant[i]) m_ent = m_ent | ent[i];
        end
    end

    assign m_hit = seen[N_ENT];

    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R4
    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        eq[0] |-> (m_ent.preg == ent[0].preg)); // R4
    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        m_hit |-> m_ent.vld); // R3

endmodule

// File: rtl/pred_mask_gen.sv
// Module: pred_mask_gen
// Builds the element enable and zeroing masks from the registered lookup
// result, the captured vector length and the predicate register contents.
// Assumes pred_data belongs to the register named by the current result.
module pred_mask_gen #(
    parameter int ELEM_MAX = 16,
    localparam int VL_W = $clog2(ELEM_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hit,
    input  logic                inv,
    input  logic                zero,
    input  logic [VL_W-1:0]     vl,
    input  logic [ELEM_MAX-1:0] pred_data,
    output logic [ELEM_MAX-1:0] en_mask,
    output logic [ELEM_MAX-1:0] zero_mask
);

    logic [ELEM_MAX-1:0] lim;
    logic [ELEM_MAX-1:0] raw;

    genvar g;
    generate
        for (g = 0; g < ELEM_MAX; g++) begin : g_lim
            // Tail limit: element g is live only below the vector length.
            assign lim[g] = (vl > VL_W'(g));
        end
    endgenerate

    // Apply the invert flag to the predicate bits.
    assign raw = pred_data ^ {ELEM_MAX{inv}};

    // Mask select: predicated on a hit, all live elements on a miss.
    always_comb begin
        if (hit) begin
            en_mask   = raw & lim;
            zero_mask = zero ? (~raw & lim) : '0;
        end else begin
            en_mask   = lim;
            zero_mask = '0;
        end
    end

    AST_MASKS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (en_mask & zero_mask) == '0); // R7
    AST_TAIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_mask >> vl) == '0) && ((zero_mask >> vl) == '0)); // R9
    AST_MISS_NO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (zero_mask == '0)); // R8

endmodule

// File: rtl/pred_kv_table.sv
// Module: pred_kv_table (top)
// Content-addressed predicate table: config writes fill entries, each
// cycle a lookup is registered, and the registered result plus the fed-back
// predicate register contents give the element masks.
// Assumes pred_data is read combinationally at pred_reg by the caller.
module pred_kv_table
    import pred_pkg::*;
#(
    parameter int N_ENT    = 4,
    parameter int ELEM_MAX = 16,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int VL_W  = $clog2(ELEM_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic                cfg_fp,
    input  logic [4:0]          cfg_key,
    input  logic [4:0]          cfg_preg,
    input  logic                cfg_inv,
    input  logic                cfg_zero,
    input  logic                lk_fp,
    input  logic [4:0]          lk_reg,
    input  logic [VL_W-1:0]     lk_vl,
    input  logic [ELEM_MAX-1:0] pred_data,
    output logic                hit,
    output logic [4:0]          pred_reg,
    output logic                pred_inv,
    output logic                pred_zero,
    output logic [ELEM_MAX-1:0] en_mask,
    output logic [ELEM_MAX-1:0] zero_mask
);

    pred_ent_t [N_ENT-1:0] ent_q;
    logic                  m_hit;
    pred_ent_t             m_ent;
    logic [VL_W-1:0]       vl_q;

    pred_entry_store #(.N_ENT(N_ENT)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_fp   (cfg_fp),
        .cfg_key  (cfg_key),
        .cfg_preg (cfg_preg),
        .cfg_inv  (cfg_inv),
        .cfg_zero (cfg_zero),
        .ent_q    (ent_q)
    );

    pred_match #(.N_ENT(N_ENT)) u_match (
        .clk    (clk),
        .rst_n  (rst_n),
        .ent    (ent_q),
        .lk_fp  (lk_fp),
        .lk_reg (lk_reg),
        .m_hit  (m_hit),
        .m_ent  (m_ent)
    );

    // Result register: one-cycle lookup latency, fields zeroed on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit       <= 1'b0;
            pred_reg  <= '0;
            pred_inv  <= 1'b0;
            pred_zero <= 1'b0;
            vl_q      <= '0;
        end else begin
            hit       <= m_hit;
            pred_reg  <= m_hit ? m_ent.preg : '0;
            pred_inv  <= m_hit & m_ent.inv;
            pred_zero <= m_hit & m_ent.zero;
            vl_q      <= lk_vl;
        end
    end

    pred_mask_gen #(.ELEM_MAX(ELEM_MAX)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .inv       (pred_inv),
        .zero      (pred_zero),
        .vl        (vl_q),
        .pred_data (pred_data),
        .en_mask   (en_mask),
        .zero_mask (zero_mask)
    );

    AST_HIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        m_hit |=> hit); // R5
    AST_MISS_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        !m_hit |=> !hit); // R5
    AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (pred_reg == '0) && !pred_inv && !pred_zero); // R8

endmodule

// File: tb/pred_kv_table_bench.sv
module pred_kv_table_bench;
    localparam int NE = 4;
    localparam int EM = 16;
    localparam int VW = $clog2(EM + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_idx = '0;
    logic          cfg_fp = 1'b0;
    logic [4:0]    cfg_key = '0;
    logic [4:0]    cfg_preg = '0;
    logic          cfg_inv = 1'b0;
    logic          cfg_zero = 1'b0;
    logic          lk_fp = 1'b0;
    logic [4:0]    lk_reg = '0;
    logic [VW-1:0] lk_vl = '0;
    logic [EM-1:0] pred_data;
    logic          hit;
    logic [4:0]    pred_reg;
    logic          pred_inv;
    logic          pred_zero;
    logic [EM-1:0] en_mask;
    logic [EM-1:0] zero_mask;

    logic [EM-1:0] rf [32];
    logic          m_vld [NE];
    logic          m_fp  [NE];
    logic [4:0]    m_key [NE];
    logic [4:0]    m_preg[NE];
    logic          m_inv [NE];
    logic          m_zero[NE];

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    assign pred_data = rf[pred_reg];

    pred_kv_table #(.N_ENT(NE), .ELEM_MAX(EM)) u_pred_kv_table (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_fp(cfg_fp), .cfg_key(cfg_key),
        .cfg_preg(cfg_preg), .cfg_inv(cfg_inv), .cfg_zero(cfg_zero),
        .lk_fp(lk_fp), .lk_reg(lk_reg), .lk_vl(lk_vl), .pred_data(pred_data),
        .hit(hit), .pred_reg(pred_reg), .pred_inv(pred_inv), .pred_zero(pred_zero),
        .en_mask(en_mask), .zero_mask(zero_mask)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    function automatic logic [EM-1:0] lim_of(input int vl);
        logic [EM-1:0] m = '0;
        for (int i = 0; i < EM; i++) if (i < vl) m[i] = 1'b1;
        return m;
    endfunction

    // One lookup, optionally with a write in the same cycle.
    task automatic op(input string tag, input logic we, input int idx, input logic wfp,
                      input int wkey, input int wpreg, input logic winv, input logic wzero,
                      input logic lfp, input int lreg, input int vl);
        int w = -1;
        logic [EM-1:0] lim, e_en, e_zm, raw;
        logic e_hit, e_inv, e_zero;
        logic [4:0] e_preg;
        for (int i = NE - 1; i >= 0; i--)
            if (m_vld[i] && m_fp[i] == lfp && m_key[i] == 5'(lreg)) w = i;
        e_hit = (w >= 0);
        e_preg = e_hit ? m_preg[w] : 5'd0;
        e_inv = e_hit ? m_inv[w] : 1'b0;
        e_zero = e_hit ? m_zero[w] : 1'b0;
        lim = lim_of(vl);
        raw = rf[e_preg] ^ {EM{e_inv}};
        e_en = e_hit ? (raw & lim) : lim;
        e_zm = (e_hit && e_zero) ? (~raw & lim) : '0;
        cfg_we = we; cfg_idx = 2'(idx); cfg_fp = wfp; cfg_key = 5'(wkey);
        cfg_preg = 5'(wpreg); cfg_inv = winv; cfg_zero = wzero;
        lk_fp = lfp; lk_reg = 5'(lreg); lk_vl = VW'(vl);
        @(posedge clk);
        if (we) begin
            m_vld[idx] = 1'b1; m_fp[idx] = wfp; m_key[idx] = 5'(wkey);
            m_preg[idx] = 5'(wpreg); m_inv[idx] = winv; m_zero[idx] = wzero;
        end
        @(negedge clk);
        cfg_we = 1'b0;
        chk({tag, " hit"}, 32'(hit), 32'(e_hit));
        chk({tag, " preg"}, 32'(pred_reg), 32'(e_preg));
        chk({tag, " flags"}, {30'd0, pred_inv, pred_zero}, {30'd0, e_inv, e_zero});
        chk({tag, " en"}, 32'(en_mask), 32'(e_en));
        chk({tag, " zm"}, 32'(zero_mask), 32'(e_zm));
    endtask

    task automatic look(input string tag, input logic lfp, input int lreg, input int vl);
        op(tag, 1'b0, 0, 1'b0, 0, 0, 1'b0, 1'b0, lfp, lreg, vl);
    endtask

    task automatic wr(input string tag, input int idx, input logic wfp, input int wkey,
                      input int wpreg, input logic winv, input logic wzero);
        op(tag, 1'b1, idx, wfp, wkey, wpreg, winv, wzero, 1'b0, 0, EM);
    endtask

    initial begin
        #(5.0 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 32; i++) rf[i] = EM'($urandom);
        for (int i = 0; i < NE; i++) begin
            m_vld[i] = 0; m_fp[i] = 0; m_key[i] = 0; m_preg[i] = 0; m_inv[i] = 0; m_zero[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk("R10 hit", 32'(hit), 0);
        chk("R10 preg", 32'(pred_reg), 0);
        chk("R10 en", 32'(en_mask), 0);
        chk("R10 zm", 32'(zero_mask), 0);
        rst_n = 1'b1;
        // R3: empty table misses; R8 miss masks
        look("R3_empty", 1'b0, 0, 16);
        look("R8_miss", 1'b0, 7, 5);
        // R2: write and lookup same key together -> still a miss
        op("R2_same", 1'b1, 0, 1'b0, 7, 12, 1'b0, 1'b0, 1'b0, 7, 8);
        // R1 / R5 / R6: next cycle sees it
        look("R1_after", 1'b0, 7, 8);
        look("R6_full", 1'b0, 7, 16);
        // R3: file bit differs -> miss
        look("R3_fpbit", 1'b1, 7, 16);
        // R4: duplicates in entries 3 and 1, entry 1 wins
        wr("R4_w3", 3, 1'b1, 9, 20, 1'b1, 1'b1);
        wr("R4_w1", 1, 1'b1, 9, 21, 1'b0, 1'b1);
        look("R4_low", 1'b1, 9, 16);
        // R7: invert plus zeroing
        wr("R7_w2", 2, 1'b0, 3, 4, 1'b1, 1'b1);
        look("R7_invzero", 1'b0, 3, 11);
        // R9: tail bounds
        look("R9_vl0", 1'b0, 3, 0);
        look("R9_vl31", 1'b0, 3, 31);
        look("R9_missvl31", 1'b0, 30, 31);
        // R1: overwrite replaces all fields
        wr("R1_ow", 1, 1'b0, 9, 5, 1'b1, 1'b0);
        look("R1_ow_old", 1'b1, 9, 16);
        look("R1_ow_new", 1'b0, 9, 16);
        // Random mix (R1 R2 R4 R6 R7 R8 R9)
        for (int n = 0; n < 400; n++) begin
            logic dow = ($urandom % 3) == 0;
            op("RND_R6_R7", dow, int'($urandom % NE), 1'($urandom), int'($urandom % 8),
               int'($urandom % 32), 1'($urandom), 1'($urandom),
               1'($urandom), int'($urandom % 8), int'($urandom % 20));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule